// File: doc/BRIEF.md
# Packed Compare and Lane-Select Unit

This unit executes a small family of 32-bit packed-data operations. A compare operation splits both operand words into lanes and tests every lane pair for equality, less-than or less-or-equal. The lanes are either four unsigned bytes or two signed halfwords. Each lane yields one condition bit, and bit i belongs to lane i counted from the least significant end. Depending on the sub-operation, the per-lane bits are written to a 4-bit condition field held inside the unit, returned as a zero-extended result word, or both.

A later select operation reads the stored condition field and builds a result lane by lane. Each lane comes from the first operand when its condition bit is set and from the second operand otherwise. The field therefore carries state from one instruction to the next. A pack-swap operation joins halfwords taken from the two operands.

Results and their write-enable are registered, one cycle after the request. The `dst_zero` input tells the unit that the destination of the current request is the hard-wired zero register. A request that would write a destination is then dropped entirely.

Top module: `simd_cmp_pick_unit`

## Requirements
- R1: After reset the condition field is 0, and `wr_en`, `illegal_op` and `result` are 0.
- R2: Sub-ops 0x00, 0x01 and 0x02 compare the four unsigned byte lanes (equal, less-than, less-or-equal). They write condition bit i (lane i, bits 8i+7:8i) into all four field bits, assert no `wr_en` and leave `result` unchanged, even when `dst_zero` is 1.
- R3: Sub-ops 0x04, 0x05 and 0x06 perform the same byte comparisons. They return the 4-bit mask zero-extended in `result` with `wr_en`, and the condition field is unchanged.
- R4: Sub-ops 0x18, 0x19 and 0x1A perform the byte comparisons and write the mask both to the whole condition field and, zero-extended, to `result` with `wr_en`.
- R5: Sub-ops 0x08, 0x09 and 0x0A compare the two halfwords as signed two's-complement values. They write only field bits 1:0 (bit 0 from bits 15:0) and keep field bits 3:2.
- R6: Sub-op 0x03 selects byte lane i of `result` from `opnd_a` when field bit i is 1, and from `opnd_b` otherwise.
- R7: Sub-op 0x0B selects halfword lane i (i = 0, 1) of `result` from `opnd_a` when field bit i is 1, and from `opnd_b` otherwise.
- R8: Sub-op 0x0E returns `opnd_a[15:0]` in `result[31:16]` and `opnd_b[31:16]` in `result[15:0]`.
- R9: A request with `dst_zero` = 1 for a destination-writing sub-op (0x03-0x06, 0x0B, 0x0E, 0x18-0x1A) has no effect: no `wr_en`, `result` held and condition field unchanged.
- R10: Any other sub-op code pulses `illegal_op` for one cycle, one cycle after the request, with no `wr_en`, no `result` change and no field change.
- R11: `wr_en` is high for exactly the cycle after an accepted destination-writing request, and a cycle without `req_valid` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented this cycle |
| sub_op | input | 5 | Sub-operation code |
| dst_zero | input | 1 | Destination of this request is the zero register |
| opnd_a | input | 32 | First operand word |
| opnd_b | input | 32 | Second operand word |
| result | output | 32 | Registered result word |
| wr_en | output | 1 | Destination write strobe for `result` |
| illegal_op | output | 1 | Unrecognised sub-op seen in the previous cycle |

## Verification
The bench builds the unit with its default widths: a 32-bit word, 8-bit byte lanes and 16-bit halfword lanes, which gives a 4-bit condition field. With these values, lanes whose top bit is set behave differently as signed halfwords than as unsigned bytes, and a halfword compare can be seen leaving field bits 3:2 untouched. The field is not brought out of the unit, so the bench reads it through a byte select of all-ones against zero and then checks that every lane follows the bit it expects.

// File: rtl/simd_cp_pkg.sv
package simd_cp_pkg;

  typedef enum logic [1:0] {
    REL_EQ   = 2'd0,
    REL_LT   = 2'd1,
    REL_LE   = 2'd2,
    REL_NONE = 2'd3
  } rel_e;

  typedef enum logic [3:0] {
    K_FLAG_B,
    K_RES_B,
    K_BOTH_B,
    K_FLAG_H,
    K_PICK_B,
    K_PICK_H,
    K_PACK,
    K_ILLEGAL
  } kind_e;

  function automatic kind_e decode_kind(input logic [4:0] code);
    kind_e k;
    case (code)
      5'h00, 5'h01, 5'h02: k = K_FLAG_B;
      5'h04, 5'h05, 5'h06: k = K_RES_B;
      5'h18, 5'h19, 5'h1A: k = K_BOTH_B;
      5'h08, 5'h09, 5'h0A: k = K_FLAG_H;
      5'h03:               k = K_PICK_B;
      5'h0B:               k = K_PICK_H;
      5'h0E:               k = K_PACK;
      default:             k = K_ILLEGAL;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/sp_reset_sync.sv
module sp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sp_lane_compare.sv
module sp_lane_compare #(
  parameter int LANE_W     = 8,
  parameter int LANES      = 4,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic [LANE_W*LANES-1:0] a,
  input  logic [LANE_W*LANES-1:0] b,
  input  simd_cp_pkg::rel_e       rel,
  output logic [LANES-1:0]        mask
);
  import simd_cp_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    logic              is_eq, is_lt;

    assign la    = a[g*LANE_W +: LANE_W];
    assign lb    = b[g*LANE_W +: LANE_W];
    assign is_eq = (la == lb);

    if (SIGNED_CMP) begin : g_signed
      assign is_lt = ($signed(la) < $signed(lb));
    end else begin : g_unsigned
      assign is_lt = (la < lb);
    end

    always_comb begin
      case (rel)
        REL_EQ:  mask[g] = is_eq;
        REL_LT:  mask[g] = is_lt;
        REL_LE:  mask[g] = is_lt | is_eq;
        default: mask[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sp_cond_field.sv
module sp_cond_field #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] wr_bits,
  input  logic [FIELD_W-1:0] din,
  output logic [FIELD_W-1:0] field
);
  logic [FIELD_W-1:0] field_q, field_nxt;

  always_comb begin
    for (int i = 0; i < FIELD_W; i++) begin
      field_nxt[i] = wr_bits[i] ? din[i] : field_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            field_q <= '0;
    else if (|wr_bits)     field_q <= field_nxt;
  end

  assign field = field_q;

  // R9, R10: a cycle with no write enable leaves every field bit intact
  assert_field_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bits == '0) |=> $stable(field_q));

  // R5: bits without a write enable keep their value during a partial write
  assert_partial_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bits != '0) |=> ((field_q & ~$past(wr_bits)) == ($past(field_q) & ~$past(wr_bits))));
endmodule

// File: rtl/sp_pick_pack.sv
module sp_pick_pack #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int HALF_W  = 16,
  parameter int FIELD_W = 4
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic [FIELD_W-1:0] field,
  output logic [DATA_W-1:0]  pick_bytes,
  output logic [DATA_W-1:0]  pick_halves,
  output logic [DATA_W-1:0]  packed_word
);
  localparam int BYTE_LANES = DATA_W / BYTE_W;
  localparam int HALF_LANES = DATA_W / HALF_W;

  for (genvar g = 0; g < BYTE_LANES; g++) begin : g_pb
    assign pick_bytes[g*BYTE_W +: BYTE_W] =
      field[g] ? a[g*BYTE_W +: BYTE_W] : b[g*BYTE_W +: BYTE_W];
  end

  for (genvar g = 0; g < HALF_LANES; g++) begin : g_ph
    assign pick_halves[g*HALF_W +: HALF_W] =
      field[g] ? a[g*HALF_W +: HALF_W] : b[g*HALF_W +: HALF_W];
  end

  assign packed_word = {a[HALF_W-1:0], b[DATA_W-1 -: HALF_W]};
endmodule

// File: rtl/simd_cmp_pick_unit.sv
module simd_cmp_pick_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [4:0]        sub_op,
  input  logic              dst_zero,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              illegal_op
);
  import simd_cp_pkg::*;

  localparam int BYTE_LANES = DATA_W / BYTE_W;
  localparam int HALF_LANES = DATA_W / HALF_W;
  localparam int FIELD_W    = BYTE_LANES;

  logic rst_ns;
  sp_reset_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  // ---- decode ----
  kind_e kind;
  rel_e  rel;
  logic  writes_dest, accept, is_illegal;

  always_comb begin
    kind        = decode_kind(sub_op);
    rel         = rel_e'(sub_op[1:0]);
    is_illegal  = (kind == K_ILLEGAL);
    writes_dest = (kind == K_RES_B) || (kind == K_BOTH_B) || (kind == K_PICK_B) ||
                  (kind == K_PICK_H) || (kind == K_PACK);
    accept      = req_valid && !is_illegal && !(writes_dest && dst_zero);
  end

  // ---- lane compares ----
  logic [BYTE_LANES-1:0] byte_mask;
  logic [HALF_LANES-1:0] half_mask;

  sp_lane_compare #(.LANE_W(BYTE_W), .LANES(BYTE_LANES), .SIGNED_CMP(1'b0)) u_cmp_b (
    .a(opnd_a), .b(opnd_b), .rel(rel), .mask(byte_mask));

  sp_lane_compare #(.LANE_W(HALF_W), .LANES(HALF_LANES), .SIGNED_CMP(1'b1)) u_cmp_h (
    .a(opnd_a), .b(opnd_b), .rel(rel), .mask(half_mask));

  // ---- condition field ----
  logic [FIELD_W-1:0] field, fld_wr, fld_din;

  always_comb begin
    fld_wr  = '0;
    fld_din = FIELD_W'(byte_mask);
    if (accept) begin
      case (kind)
        K_FLAG_B, K_BOTH_B: fld_wr = '1;
        K_FLAG_H: begin
          fld_wr  = FIELD_W'({HALF_LANES{1'b1}});
          fld_din = FIELD_W'(half_mask);
        end
        default: fld_wr = '0;
      endcase
    end
  end

  sp_cond_field #(.FIELD_W(FIELD_W)) u_field (
    .clk(clk), .rst_n(rst_ns), .wr_bits(fld_wr), .din(fld_din), .field(field));

  // ---- select / pack ----
  logic [DATA_W-1:0] pick_b, pick_h, pack_w;

  sp_pick_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W), .FIELD_W(FIELD_W)) u_pp (
    .a(opnd_a), .b(opnd_b), .field(field),
    .pick_bytes(pick_b), .pick_halves(pick_h), .packed_word(pack_w));

  // ---- output next state ----
  logic [DATA_W-1:0] result_nxt;
  logic              res_en, wr_nxt, ill_nxt;

  always_comb begin
    case (kind)
      K_RES_B, K_BOTH_B: result_nxt = DATA_W'(byte_mask);
      K_PICK_B:          result_nxt = pick_b;
      K_PICK_H:          result_nxt = pick_h;
      K_PACK:            result_nxt = pack_w;
      default:           result_nxt = '0;
    endcase
    res_en  = accept && writes_dest;
    wr_nxt  = res_en;
    ill_nxt = req_valid && is_illegal;
  end

  // ---- output registers ----
  logic [DATA_W-1:0] result_q;
  logic              wr_q, ill_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      result_q <= '0;
      wr_q     <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      if (res_en) result_q <= result_nxt;
      wr_q  <= wr_nxt;
      ill_q <= ill_nxt;
    end
  end

  assign result     = result_q;
  assign wr_en      = wr_q;
  assign illegal_op = ill_q;

  // R11: a write strobe only follows a request
  assert_wr_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en |-> $past(req_valid));

  // R9: zero-register destination suppresses the write
  assert_dst_zero_no_write_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && dst_zero && writes_dest) |=> !wr_en);

  // R10: illegal flag and write strobe never together, and no result change
  assert_illegal_excl_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    illegal_op |-> (!wr_en && $stable(result)));

  // R11: without a write strobe the result word holds
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    !wr_en |-> $stable(result));
endmodule

// File: tb/tb_simd_cmp_pick_unit.sv
`timescale 1ns/1ps
module tb_simd_cmp_pick_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [4:0]  sub_op;
  logic        dst_zero;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] result;
  logic        wr_en, illegal_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] exp_field;

  always #2 clk = ~clk;

  simd_cmp_pick_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sub_op(sub_op),
    .dst_zero(dst_zero), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .wr_en(wr_en), .illegal_op(illegal_op));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] byte_cmp(input logic [1:0] rel, input logic [31:0] a, input logic [31:0] b);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] x, y;
      x = a[8*i +: 8]; y = b[8*i +: 8];
      m[i] = (rel == 2'd0) ? (x == y) : (rel == 2'd1) ? (x < y) : (x <= y);
    end
    return m;
  endfunction

  function automatic logic [1:0] half_cmp(input logic [1:0] rel, input logic [31:0] a, input logic [31:0] b);
    logic [1:0] m;
    for (int i = 0; i < 2; i++) begin
      int x, y;
      x = int'($signed(a[16*i +: 16])); y = int'($signed(b[16*i +: 16]));
      m[i] = (rel == 2'd0) ? (x == y) : (rel == 2'd1) ? (x < y) : (x <= y);
    end
    return m;
  endfunction

  // issue one request; outputs of it are visible on return
  task automatic issue(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b, input logic dz);
    @(negedge clk);
    req_valid = 1'b1; sub_op = op; opnd_a = a; opnd_b = b; dst_zero = dz;
    @(negedge clk);
    req_valid = 1'b0; dst_zero = 1'b0;
  endtask

  // read the condition field through a byte select of ones against zero
  task automatic read_field(output logic [3:0] f);
    issue(5'h03, 32'hFFFF_FFFF, 32'h0, 1'b0);
    for (int i = 0; i < 4; i++) f[i] = (result[8*i +: 8] == 8'hFF);
  endtask

  task automatic t_reset();
    logic [3:0] f;
    chk("R1 result", result, 32'h0);
    chk("R1 wr_en", {31'h0, wr_en}, 32'h0);
    chk("R1 illegal_op", {31'h0, illegal_op}, 32'h0);
    read_field(f);
    chk("R1 field", {28'h0, f}, 32'h0);
    exp_field = 4'h0;
  endtask

  task automatic t_flag_bytes();
    logic [3:0] f;
    logic [31:0] a = 32'h1020_3040, b = 32'h1030_2040, held;
    for (int r = 0; r < 3; r++) begin
      held = result;
      issue(5'(r), a, b, (r == 2));   // R2: dst_zero has no influence
      chk("R2 no wr_en", {31'h0, wr_en}, 32'h0);
      chk("R2 result held", result, held);
      exp_field = byte_cmp(2'(r), a, b);
      read_field(f);
      chk("R2 field", {28'h0, f}, {28'h0, exp_field});
    end
  endtask

  task automatic t_result_bytes();
    logic [3:0] f;
    logic [31:0] a = 32'h80FF_0001, b = 32'h7FFF_0100;
    for (int r = 0; r < 3; r++) begin
      issue(5'h04 + 5'(r), a, b, 1'b0);
      chk("R3 wr_en", {31'h0, wr_en}, 32'h1);
      chk("R3 result", result, {28'h0, byte_cmp(2'(r), a, b)});
    end
    read_field(f);
    chk("R3 field unchanged", {28'h0, f}, {28'h0, exp_field});
  endtask

  task automatic t_both();
    logic [3:0] f;
    logic [31:0] a = 32'h80FF_0001, b = 32'h7FFF_0100;
    for (int r = 0; r < 3; r++) begin
      issue(5'h18 + 5'(r), a, b, 1'b0);
      exp_field = byte_cmp(2'(r), a, b);
      chk("R4 wr_en", {31'h0, wr_en}, 32'h1);
      chk("R4 result", result, {28'h0, exp_field});
      read_field(f);
      chk("R4 field", {28'h0, f}, {28'h0, exp_field});
    end
  endtask

  task automatic t_half_flags();
    logic [3:0] f;
    logic [31:0] a = 32'h8000_0005, b = 32'h7FFF_0005;
    for (int r = 0; r < 3; r++) begin
      issue(5'h00, 32'h1234_5678, 32'h1234_5678, 1'b0);  // field = 1111
      issue(5'h08 + 5'(r), a, b, 1'b0);
      chk("R5 no wr_en", {31'h0, wr_en}, 32'h0);
      exp_field = {2'b11, half_cmp(2'(r), a, b)};
      read_field(f);
      chk("R5 field", {28'h0, f}, {28'h0, exp_field});
    end
  endtask

  task automatic t_pick_bytes();
    logic [31:0] a = 32'hA1A2_A3A4, b = 32'hB1B2_B3B4, e;
    issue(5'h18, 32'h0011_2233, 32'h0099_2277, 1'b0);   // field = 1010
    exp_field = 4'b1010;
    issue(5'h03, a, b, 1'b0);
    for (int i = 0; i < 4; i++) e[8*i +: 8] = exp_field[i] ? a[8*i +: 8] : b[8*i +: 8];
    chk("R6 wr_en", {31'h0, wr_en}, 32'h1);
    chk("R6 result", result, e);
  endtask

  task automatic t_pick_halves();
    logic [31:0] a = 32'hAAAA_5555, b = 32'hCCCC_3333;
    issue(5'h0B, a, b, 1'b0);   // field 1010: bit0 = 0, bit1 = 1
    chk("R7 result 1010", result, 32'hAAAA_3333);
    issue(5'h18, 32'h0000_0001, 32'h0000_0001, 1'b0);   // field = 1111
    issue(5'h08, 32'h0001_0007, 32'h0002_0007, 1'b0);   // field = 11 01
    exp_field = 4'b1101;
    issue(5'h0B, a, b, 1'b0);
    chk("R7 result 1101", result, 32'hCCCC_5555);
  endtask

  task automatic t_pack();
    issue(5'h0E, 32'h1111_2222, 32'h3333_4444, 1'b0);
    chk("R8 wr_en", {31'h0, wr_en}, 32'h1);
    chk("R8 result", result, 32'h2222_3333);
  endtask

  task automatic t_dst_zero();
    logic [3:0] f;
    logic [31:0] held;
    held = result;
    issue(5'h19, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    chk("R9 no wr_en both", {31'h0, wr_en}, 32'h0);
    chk("R9 result held both", result, held);
    issue(5'h0E, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1);
    chk("R9 no wr_en pack", {31'h0, wr_en}, 32'h0);
    chk("R9 result held pack", result, held);
    read_field(f);
    chk("R9 field unchanged", {28'h0, f}, {28'h0, exp_field});
  endtask

  task automatic t_illegal();
    logic [3:0] f;
    logic [31:0] held;
    held = result;
    issue(5'h07, 32'h1, 32'h2, 1'b0);
    chk("R10 illegal_op", {31'h0, illegal_op}, 32'h1);
    chk("R10 no wr_en", {31'h0, wr_en}, 32'h0);
    chk("R10 result held", result, held);
    @(negedge clk);
    chk("R10 pulse ends", {31'h0, illegal_op}, 32'h0);
    issue(5'h1F, 32'h0, 32'h0, 1'b0);
    chk("R10 illegal_op 1F", {31'h0, illegal_op}, 32'h1);
    read_field(f);
    chk("R10 field unchanged", {28'h0, f}, {28'h0, exp_field});
  endtask

  task automatic t_timing();
    logic [31:0] held;
    issue(5'h0E, 32'h0000_ABCD, 32'h1234_0000, 1'b0);
    held = result;
    chk("R11 wr_en after req", {31'h0, wr_en}, 32'h1);
    @(negedge clk);
    chk("R11 wr_en one cycle", {31'h0, wr_en}, 32'h0);
    sub_op = 5'h0E; opnd_a = 32'h5555_5555; opnd_b = 32'h6666_6666;
    @(negedge clk);
    chk("R11 idle no wr_en", {31'h0, wr_en}, 32'h0);
    chk("R11 idle result held", result, held);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; sub_op = 5'h0; dst_zero = 1'b0;
    opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_flag_bytes();
    t_result_bytes();
    t_both();
    t_half_flags();
    t_pick_bytes();
    t_pick_halves();
    t_pack();
    t_dst_zero();
    t_illegal();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule